// File: doc/BRIEF.md
# Byte-Lane EDAC Word Sequencer

This block connects a 32-bit word master to a byte-wide RAM or PROM bank that keeps error-correction checkbits. Each word request becomes five byte accesses on the memory side. Four of them move the data bytes at consecutive byte addresses. The fifth moves the checkbit byte over the same byte lane. There is no separate checkbit bus in this mode.

The checkbit byte is stored in the same bank, at an address mirrored down from the top of the bank. Word index n uses the byte at the bank's all-ones address minus n. The data area therefore grows upward from the bottom, and the checkbit area grows downward from the top. The chip select stays asserted through all five accesses, so the bank remains selected during the checkbit transfer.

The checkbit code is computed and checked outside this block. On a write, the master supplies the checkbits. On a read, the assembled word and its checkbit byte are handed to the external checker with a one-cycle valid pulse. A request marked as targeting an SDRAM region is refused without touching the memory port.

Top module: `bytelane_edac_seq`

## Requirements
- R1: After synchronous reset, the outputs mem_cs, mem_we, mem_oe, req_ack, req_err and rd_valid are all low.
- R2: For word index n, the first four byte accesses use byte addresses 4n, 4n+1, 4n+2 and 4n+3, in that order, and the fifth access is the checkbit access.
- R3: The checkbit access uses byte address (2^BANK_AW - 1) - n. Word 0 maps to the all-ones bank address and word 1 maps to all-ones minus one.
- R4: mem_cs stays high from the first byte access to the end of the fifth access with no gap. While mem_cs is high, exactly one of mem_we and mem_oe is high, and mem_we is high only for writes. When mem_cs is low, both strobes are low.
- R5: On a write, the byte lane is big-endian. Access 0 carries word bits 31:24, access 3 carries bits 7:0, and access 4 carries req_wcb.
- R6: A byte access completes only in a cycle where mem_rdy is high. While mem_rdy is low, mem_addr and mem_wdata hold their values.
- R7: req_ack is a single-cycle pulse. It is raised in the cycle after the fifth access completes, and at no other time for a memory request.
- R8: On a read, rd_valid pulses together with req_ack. In that cycle, rd_word holds the four bytes read (the first byte in bits 31:24) and rd_cb holds the checkbit byte.
- R9: A request with req_sdram high is acknowledged in the next cycle with req_err high and no memory access. req_err is low on every acknowledge of a memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Word request pending; held until req_ack |
| req_write | input | 1 | 1 = word write, 0 = word read |
| req_sdram | input | 1 | Request targets an SDRAM region (refused) |
| req_word | input | BANK_AW-2 | Word index n within the bank |
| req_wdata | input | 32 | Write data word |
| req_wcb | input | 8 | Write checkbits |
| req_ack | output | 1 | Request complete pulse |
| req_err | output | 1 | Request refused (with req_ack) |
| rd_valid | output | 1 | Read word and checkbits valid pulse |
| rd_word | output | 32 | Assembled read word |
| rd_cb | output | 8 | Read checkbit byte |
| mem_cs | output | 1 | Bank chip select |
| mem_we | output | 1 | Byte write strobe |
| mem_oe | output | 1 | Byte read strobe |
| mem_addr | output | BANK_AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| mem_rdy | input | 1 | Current byte access completes this cycle |

## Verification
The bench builds the block with BANK_AW set to 12, so the bank is 4 KB and a full byte model of it fits in the bench. At that size the top of the bank can be reached: the mirror of word 0 lands on 0xFFF, and the highest word index (1023) writes its data into the top bytes while its checkbit byte sits at 0xC00. This puts the point where the upward data area meets the downward checkbit area inside the test. The same size lets random word indices cover a large share of the bank while random ready stalls stretch each access.

// File: rtl/bles_pkg.sv
package bles_pkg;

    localparam int WORD_BYTES = 4;
    localparam int BEATS      = WORD_BYTES + 1;
    localparam int BEAT_W     = $clog2(BEATS);

    typedef logic [BEAT_W-1:0] beat_t;

    localparam beat_t CB_BEAT = beat_t'(WORD_BYTES);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic        write;
        logic [31:0] wdata;
        logic [7:0]  wcb;
    } op_t;

    // Big-endian lane pick: beat 0 is the most significant byte.
    function automatic logic [7:0] lane_byte(input logic [31:0] w, input beat_t b);
        logic [7:0] r;
        case (b)
            beat_t'(0): r = w[31:24];
            beat_t'(1): r = w[23:16];
            beat_t'(2): r = w[15:8];
            default:    r = w[7:0];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bles_seq_fsm.sv
module bles_seq_fsm
    import bles_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_sdram,
    input  logic       mem_rdy,
    output seq_state_e state,
    output beat_t      beat,
    output logic       accept,
    output logic       last_hs,
    output logic       ack,
    output logic       err
);

    seq_state_e state_q;
    beat_t      beat_q;
    logic       ack_q;
    logic       err_q;

    assign accept  = (state_q == ST_IDLE) && req_valid && !ack_q;
    assign last_hs = (state_q == ST_XFER) && mem_rdy && (beat_q == CB_BEAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (req_sdram) begin
                            ack_q <= 1'b1;
                            err_q <= 1'b1;
                        end else begin
                            state_q <= ST_XFER;
                            beat_q  <= '0;
                        end
                    end
                end
                ST_XFER: begin
                    if (mem_rdy) begin
                        if (beat_q == CB_BEAT) begin
                            state_q <= ST_IDLE;
                            beat_q  <= '0;
                            ack_q   <= 1'b1;
                        end else begin
                            beat_q <= beat_q + beat_t'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state = state_q;
    assign beat  = beat_q;
    assign ack   = ack_q;
    assign err   = err_q;

    assert_beat_range_R2: assert property (@(posedge clk) disable iff (rst)
        beat_q <= CB_BEAT);

    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);

    assert_err_with_ack_R9: assert property (@(posedge clk) disable iff (rst)
        err_q |-> ack_q);

    assert_beat_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_XFER) && !mem_rdy |=> (state_q == ST_XFER) && $stable(beat_q));

endmodule

// File: rtl/bles_addr_gen.sv
module bles_addr_gen
    import bles_pkg::*;
#(
    parameter int BANK_AW = 28,
    localparam int IDX_W  = BANK_AW - 2
) (
    input  logic [IDX_W-1:0]   word_idx,
    input  beat_t              beat,
    output logic [BANK_AW-1:0] addr
);

    logic [BANK_AW-1:0] data_addr;
    logic [BANK_AW-1:0] cb_addr;

    // Data bytes ascend from 4n; the checkbit byte mirrors down from the
    // top of the bank: all-ones minus n, i.e. the inverted zero-extended index.
    assign data_addr = {word_idx, beat[1:0]};
    assign cb_addr   = ~{2'b00, word_idx};
    assign addr      = (beat == CB_BEAT) ? cb_addr : data_addr;

endmodule

// File: rtl/bles_lane_mux.sv
module bles_lane_mux
    import bles_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  op_t         op,
    input  beat_t       beat,
    input  logic        capture,
    input  logic [7:0]  rdata,
    output logic [7:0]  wbyte,
    output logic [31:0] word_out,
    output logic [7:0]  cb_out
);

    logic [7:0] byte_q [WORD_BYTES];
    logic [7:0] cb_q;

    assign wbyte = !op.write        ? 8'h00 :
                   (beat == CB_BEAT) ? op.wcb :
                                       lane_byte(op.wdata, beat);

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q[g] <= '0;
            end else if (capture && beat == beat_t'(g)) begin
                byte_q[g] <= rdata;
            end
        end
        assign word_out[31-8*g -: 8] = byte_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cb_q <= '0;
        end else if (capture && beat == CB_BEAT) begin
            cb_q <= rdata;
        end
    end

    assign cb_out = cb_q;

endmodule

// File: rtl/bytelane_edac_seq.sv
module bytelane_edac_seq
    import bles_pkg::*;
#(
    parameter int BANK_AW = 28,
    localparam int IDX_W  = BANK_AW - 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_sdram,
    input  logic [IDX_W-1:0]   req_word,
    input  logic [31:0]        req_wdata,
    input  logic [7:0]         req_wcb,
    output logic               req_ack,
    output logic               req_err,
    output logic               rd_valid,
    output logic [31:0]        rd_word,
    output logic [7:0]         rd_cb,
    output logic               mem_cs,
    output logic               mem_we,
    output logic               mem_oe,
    output logic [BANK_AW-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_rdy
);

    seq_state_e         state;
    beat_t              beat;
    logic               accept;
    logic               last_hs;
    op_t                op_q;
    logic [IDX_W-1:0]   idx_q;
    logic               rdv_q;
    logic               in_xfer;

    bles_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_sdram (req_sdram),
        .mem_rdy   (mem_rdy),
        .state     (state),
        .beat      (beat),
        .accept    (accept),
        .last_hs   (last_hs),
        .ack       (req_ack),
        .err       (req_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= '0;
            idx_q <= '0;
            rdv_q <= 1'b0;
        end else begin
            if (accept) begin
                op_q.write <= req_write;
                op_q.wdata <= req_wdata;
                op_q.wcb   <= req_wcb;
                idx_q      <= req_word;
            end
            rdv_q <= last_hs && !op_q.write;
        end
    end

    assign in_xfer = (state == ST_XFER);

    bles_addr_gen #(.BANK_AW(BANK_AW)) u_addr (
        .word_idx (idx_q),
        .beat     (beat),
        .addr     (mem_addr)
    );

    bles_lane_mux u_lane (
        .clk      (clk),
        .rst      (rst),
        .op       (op_q),
        .beat     (beat),
        .capture  (in_xfer && mem_rdy && !op_q.write),
        .rdata    (mem_rdata),
        .wbyte    (mem_wdata),
        .word_out (rd_word),
        .cb_out   (rd_cb)
    );

    assign mem_cs   = in_xfer;
    assign mem_we   = in_xfer && op_q.write;
    assign mem_oe   = in_xfer && !op_q.write;
    assign rd_valid = rdv_q;

    assert_cs_held_R4: assert property (@(posedge clk) disable iff (rst)
        mem_cs && !(mem_rdy && beat == CB_BEAT) |=> mem_cs);

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        mem_cs ? (mem_we ^ mem_oe) : !(mem_we || mem_oe));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        mem_cs && !mem_rdy |=> mem_cs && $stable(mem_addr) && $stable(mem_wdata));

    assert_ack_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        req_ack && !req_err |-> $past(mem_cs && mem_rdy) && !mem_cs);

    assert_rdvalid_R8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> req_ack && !req_err);

    assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        req_err |-> !mem_cs && !rd_valid);

endmodule

// File: tb/bytelane_edac_seq_test.sv
module bytelane_edac_seq_test;

    localparam int AW   = 12;
    localparam int IW   = AW - 2;
    localparam int SIZE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, req_sdram = 1'b0;
    logic [IW-1:0] req_word = '0;
    logic [31:0]   req_wdata = '0;
    logic [7:0]    req_wcb = '0;
    logic          req_ack, req_err, rd_valid;
    logic [31:0]   rd_word;
    logic [7:0]    rd_cb;
    logic          mem_cs, mem_we, mem_oe;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          mem_rdy = 1'b0;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    logic [7:0]  mem [SIZE];
    logic [31:0] ref_w [512];
    logic [7:0]  ref_c [512];
    bit          ref_ok [512];

    always #10 clk = ~clk;   // 50 MHz

    bytelane_edac_seq #(.BANK_AW(AW)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_sdram(req_sdram),
        .req_word(req_word), .req_wdata(req_wdata), .req_wcb(req_wcb),
        .req_ack(req_ack), .req_err(req_err),
        .rd_valid(rd_valid), .rd_word(rd_word), .rd_cb(rd_cb),
        .mem_cs(mem_cs), .mem_we(mem_we), .mem_oe(mem_oe),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
    );

    // Byte-wide bank model
    always @(posedge clk)
        if (mem_cs && mem_we && mem_rdy) mem[mem_addr] <= mem_wdata;
    assign mem_rdata = mem_oe ? mem[mem_addr] : 8'h00;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input int n, input int b);
        if (b < 4) return AW'(4 * n + b);
        return AW'((SIZE - 1) - n);
    endfunction

    function automatic logic [7:0] exp_wbyte(input logic [31:0] w, input logic [7:0] c, input int b);
        if (b == 4) return c;
        return w[31 - 8 * b -: 8];
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog", 32'(cycles), 32'd150000);
            finish_run();
        end
    end

    task automatic do_op(input bit wr, input int n, input logic [31:0] wd, input logic [7:0] wc,
                         input bit sdram, input int rdy_pct,
                         output logic [31:0] got_w, output logic [7:0] got_c);
        int  beat = 0;
        int  iter = 0;
        bit  last_prev = 0;
        bit  gap = 0;
        bit  held = 0;
        bit  done = 0;
        logic [AW-1:0] held_addr = '0;
        got_w = '0; got_c = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_sdram = sdram;
        req_word = IW'(n); req_wdata = wd; req_wcb = wc;
        while (!done) begin
            @(negedge clk);
            mem_rdy = (($urandom % 100) < rdy_pct);
            #1;
            iter++;
            if (held) check(mem_addr == held_addr, "R6 address held while not ready", 32'(mem_addr), 32'(held_addr));
            held = 0;
            if (req_ack) begin
                done = 1;
                req_valid = 1'b0;
                if (sdram) begin
                    check(iter == 1 && req_err && beat == 0, "R9 refused request ack", {30'd0, req_err, 1'b0} | 32'(iter), 32'h3);
                end else begin
                    check(last_prev, "R7 ack follows fifth access", 32'(last_prev), 32'd1);
                    check(!req_err, "R9 err low on memory ack", 32'(req_err), 32'd0);
                    check(!gap, "R4 cs held across accesses", 32'(gap), 32'd0);
                    check(rd_valid == !wr, "R8 rd_valid with read ack", 32'(rd_valid), 32'(!wr));
                    got_w = rd_word; got_c = rd_cb;
                end
            end else begin
                if (last_prev) check(1'b0, "R7 ack missing", 32'd0, 32'd1);
                if (beat > 0 && beat < 5 && !mem_cs) gap = 1;
                if (mem_cs && mem_rdy) begin
                    check(mem_addr == exp_addr(n, beat), beat == 4 ? "R3 checkbit address" : "R2 data byte address",
                          32'(mem_addr), 32'(exp_addr(n, beat)));
                    check(mem_we == wr && mem_oe == !wr, "R4 strobe direction", {mem_we, mem_oe}, {wr, !wr});
                    if (wr) check(mem_wdata == exp_wbyte(wd, wc, beat), "R5 write lane byte",
                                  32'(mem_wdata), 32'(exp_wbyte(wd, wc, beat)));
                    last_prev = (beat == 4);
                    beat++;
                end else begin
                    last_prev = 0;
                    if (mem_cs) begin held = 1; held_addr = mem_addr; end
                end
                if (sdram && mem_cs) check(1'b0, "R9 refused request touched memory", 32'd1, 32'd0);
            end
            if (iter > 300) begin
                check(1'b0, "R7 ack timeout", 32'(iter), 32'd300);
                done = 1; req_valid = 1'b0;
            end
        end
        mem_rdy = 1'b0;
        @(negedge clk); #1;
        check(!req_ack, "R7 ack single pulse", 32'(req_ack), 32'd0);
    endtask

    initial begin
        logic [31:0] w;
        logic [7:0]  c;
        void'($urandom(32'd2024));
        for (int i = 0; i < SIZE; i++) mem[i] = 8'h00;
        for (int i = 0; i < 512; i++) ref_ok[i] = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check(!mem_cs && !mem_we && !mem_oe && !req_ack && !req_err && !rd_valid,
              "R1 reset outputs", {26'd0, mem_cs, mem_we, mem_oe, req_ack, req_err, rd_valid}, 32'd0);

        // Highest word: data at the top, checkbit at the meeting point
        do_op(1, 1023, 32'hA1B2C3D4, 8'h5E, 0, 100, w, c);
        check(mem[AW'(12'hC00)] == 8'h5E, "R3 top word checkbit at 0xC00", 32'(mem[AW'(12'hC00)]), 32'h5E);

        // Word 0 and word 1 mirrors, full speed
        do_op(1, 0, 32'h11223344, 8'h9C, 0, 100, w, c);
        ref_w[0] = 32'h11223344; ref_c[0] = 8'h9C; ref_ok[0] = 1;
        check(mem[AW'(12'hFFF)] == 8'h9C, "R3 word 0 checkbit at all-ones", 32'(mem[AW'(12'hFFF)]), 32'h9C);
        check(mem[0] == 8'h11 && mem[3] == 8'h44, "R5 big-endian bytes in bank", {mem[0], mem[3]}, 16'h1144);
        do_op(1, 1, 32'hDEADBEEF, 8'h3A, 0, 100, w, c);
        ref_w[1] = 32'hDEADBEEF; ref_c[1] = 8'h3A; ref_ok[1] = 1;
        check(mem[AW'(12'hFFE)] == 8'h3A, "R3 word 1 checkbit at all-ones minus one", 32'(mem[AW'(12'hFFE)]), 32'h3A);

        do_op(0, 0, '0, '0, 0, 100, w, c);
        check(w == 32'h11223344 && c == 8'h9C, "R8 read word 0", w, 32'h11223344);
        do_op(0, 1, '0, '0, 0, 40, w, c);
        check(w == 32'hDEADBEEF && c == 8'h3A, "R8 read word 1 with stalls", w, 32'hDEADBEEF);

        // Refused SDRAM-region requests
        do_op(1, 7, 32'hFFFFFFFF, 8'hFF, 1, 100, w, c);
        check(mem[28] == 8'h00, "R9 refused write left bank unchanged", 32'(mem[28]), 32'h0);
        do_op(0, 7, '0, '0, 1, 100, w, c);

        // Random mix with ready stalls
        for (int k = 0; k < 80; k++) begin
            int n = int'($urandom % 512);
            if (ref_ok[n] && ($urandom % 2 == 0)) begin
                do_op(0, n, '0, '0, 0, 60, w, c);
                check(w == ref_w[n], "R8 random read word", w, ref_w[n]);
                check(c == ref_c[n], "R8 random read checkbits", 32'(c), 32'(ref_c[n]));
            end else begin
                logic [31:0] d = $urandom;
                logic [7:0]  cb = 8'($urandom);
                do_op(1, n, d, cb, 0, 60, w, c);
                ref_w[n] = d; ref_c[n] = cb; ref_ok[n] = 1;
            end
        end

        // Reset mid-transfer returns to idle outputs
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_sdram = 1'b0; req_word = IW'(3);
        mem_rdy = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk); #1;
        check(!mem_cs && !mem_we && !req_ack, "R1 reset during transfer", {29'd0, mem_cs, mem_we, req_ack}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        finish_run();
    end

endmodule